// File: doc/BRIEF.md
# Windowed Fixed-Length Bit Correlator

This block computes a one-bit autocorrelation of the non-roll-off kind over a sequence of `SEQ_LEN` bits that arrive one per accepted beat. A leading window of `L` bits is slid against the whole sequence, so every lag it reports is a sum of exactly `L` products. The block keeps one running counter per lag. It feeds its delay line separately from its coincidence gates. While the first `L` bits arrive, both receive the live bit. After that the delay line takes zeros and the gates keep seeing the live stream, which pads the window with zeros as the data arrives.

A pulse on `start_i` latches the window length and clears the state. The sequence then streams in through a valid/ready handshake. A bit is taken on any rising edge where `in_valid_i` and `in_ready_o` are both high. The source may hold `in_valid_i` low for as long as it likes, and no data is lost. The block deasserts `in_ready_o` when it is idle and after the last bit, so no upstream beat is ever taken outside a run. The results are final after `SEQ_LEN` accepted beats. `done_o` then rises and the counts stay frozen until the next start.

Top module: `fslc_window_corr`

## Requirements
- R1: After reset, `in_ready_o` and `done_o` are low and every lag count reads zero.
- R2: A `start_i` pulse clears all lag counts, drops `done_o` and raises `in_ready_o` from the next cycle on. It also latches `win_len_i` as the window length L.
- R3: A bit is consumed only on an edge where `in_valid_i` and `in_ready_o` are both high. A cycle with `in_valid_i` low leaves every count unchanged.
- R4: Number the consumed bits x[1]..x[N] in arrival order. After the last bit, the count for lag l (bits `l*CW +: CW` of `lag_cnt_o`, with CW = clog2(N+1)) equals the sum over k = 1..L of x[k]·x[k+l], for 0 ≤ l ≤ N−L. While the run is in progress, each count gains x[t]·d[t−l] one cycle after bit t is consumed. Here d is the delay-line feed.
- R5: The delay line is fed x[t] for t ≤ L and zero for t > L, so bits after the window never act as the leading factor of any product.
- R6: Lag counts for l > N−L read zero at all times.
- R7: `done_o` rises in the cycle after the N-th bit is consumed, at the same edge where `in_ready_o` falls. It stays high and the counts stay unchanged, whatever `in_valid_i` does, until the next `start_i`.
- R8: A requested window outside 1..N−1 is replaced by N/2.
- R9: A `start_i` pulse during a run abandons the run and begins a new one with cleared counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new run; latches the window length |
| win_len_i | input | clog2(SEQ_LEN) | Requested window length L |
| in_valid_i | input | 1 | Input bit is valid |
| in_bit_i | input | 1 | Serial sequence bit |
| in_ready_o | output | 1 | Block will consume a valid bit this cycle |
| done_o | output | 1 | All SEQ_LEN bits consumed; counts are final |
| lag_cnt_o | output | SEQ_LEN*CW | Lag counts, lag l at bits l*CW +: CW |

## Verification
Any fault in the delay line, the window switch or a lag counter shows at the ports one cycle after the first consumed bit it touches. Each count is visible at every step, so a wrong tap or a feed that switches late makes the running sums drift from the reference partway through a sequence. A bit counter that is off by one makes `done_o` and `in_ready_o` move a cycle early or late. The bench compares these outputs on every cycle against a behavioural model. It also checks known final values for patterns whose counts can be worked out by hand.

// File: rtl/fslc_pkg.sv
package fslc_pkg;
  // Map a requested window onto a legal one: 1..n-1, otherwise n/2.
  function automatic int legal_window(input int req, input int n);
    return (req >= 1 && req <= n - 1) ? req : n / 2;
  endfunction
endpackage

// File: rtl/fslc_seq_ctrl.sv
module fslc_seq_ctrl #(
  parameter int SEQ_LEN = 8,
  localparam int LW = $clog2(SEQ_LEN),
  localparam int PW = $clog2(SEQ_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] win_req_i,
  input  logic          valid_i,
  input  logic          bit_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          take_o,
  output logic          feed_o,
  output logic          clr_o,
  output logic [LW-1:0] win_o
);
  import fslc_pkg::*;

  logic          busy_q, done_q;
  logic [PW-1:0] pos_q;
  logic [LW-1:0] win_q;

  assign ready_o = busy_q;
  assign done_o  = done_q;
  assign win_o   = win_q;
  assign clr_o   = start_i;
  assign take_o  = busy_q & valid_i & ~start_i;
  // Live bit into the delay line while inside the window, zero afterwards.
  assign feed_o  = bit_i & (pos_q < PW'(win_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pos_q  <= '0;
      win_q  <= LW'(SEQ_LEN / 2);
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      pos_q  <= '0;
      win_q  <= LW'(legal_window(int'(win_req_i), SEQ_LEN));
    end else if (take_o) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q == PW'(SEQ_LEN - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // R7
  ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && done_o));
  // R2
  start_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ready_o && !done_o));
  // R7
  done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(take_o));
  // R8
  win_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o >= LW'(1)) && (int'(win_o) <= SEQ_LEN - 1));
endmodule

// File: rtl/fslc_tap_line.sv
module fslc_tap_line #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             feed_i,
  output logic [DEPTH-1:0] taps_o
);
  logic [DEPTH-2:0] line_q;

  // Tap 0 is the current feed; tap i is the feed from i consumed beats ago.
  assign taps_o = {line_q, feed_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (clr_i)   line_q <= '0;
    else if (shift_i) line_q <= taps_o[DEPTH-2:0];
  end

  // R2
  line_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (line_q == '0));
endmodule

// File: rtl/fslc_lag_acc.sv
module fslc_lag_acc #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          live_i,
  input  logic          tap_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (en_i && live_i && tap_i) cnt_o <= cnt_o + 1'b1;
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(cnt_o));
endmodule

// File: rtl/fslc_window_corr.sv
module fslc_window_corr #(
  parameter int SEQ_LEN = 8,
  localparam int LW = $clog2(SEQ_LEN),
  localparam int CW = $clog2(SEQ_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [LW-1:0]         win_len_i,
  input  logic                  in_valid_i,
  input  logic                  in_bit_i,
  output logic                  in_ready_o,
  output logic                  done_o,
  output logic [SEQ_LEN*CW-1:0] lag_cnt_o
);
  logic               take, feed, clr;
  logic [LW-1:0]      win;
  logic [SEQ_LEN-1:0] taps;

  fslc_seq_ctrl #(.SEQ_LEN(SEQ_LEN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_req_i(win_len_i),
    .valid_i(in_valid_i), .bit_i(in_bit_i), .ready_o(in_ready_o),
    .done_o(done_o), .take_o(take), .feed_o(feed), .clr_o(clr), .win_o(win)
  );

  fslc_tap_line #(.DEPTH(SEQ_LEN)) line_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .shift_i(take),
    .feed_i(feed), .taps_o(taps)
  );

  for (genvar l = 0; l < SEQ_LEN; l++) begin : g_lag
    logic [CW-1:0] cnt;
    fslc_lag_acc #(.CW(CW)) acc_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(take),
      .live_i(in_bit_i), .tap_i(taps[l]), .cnt_o(cnt)
    );
    // Lags past SEQ_LEN - L hold partial sums and are masked off.
    assign lag_cnt_o[l*CW +: CW] = (l + int'(win) <= SEQ_LEN) ? cnt : '0;
  end

  // R4
  lag0_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lag_cnt_o[CW-1:0]) <= int'(win));
endmodule

// File: tb/fslc_window_corr_tb.sv
module fslc_window_corr_tb_top;
  localparam int N = 8;
  localparam int LW = $clog2(N);
  localparam int CW = $clog2(N + 1);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic [LW-1:0] win_len = '0;
  logic in_ready, done;
  logic [N*CW-1:0] lag_cnt;

  int tests = 0, fails = 0;

  // behavioural reference
  int m_cnt[N];
  bit m_fed[$];
  bit m_busy = 0, m_done = 0;
  int m_n = 0, m_win = N / 2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fslc_window_corr #(.SEQ_LEN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .win_len_i(win_len),
    .in_valid_i(in_valid), .in_bit_i(in_bit), .in_ready_o(in_ready),
    .done_o(done), .lag_cnt_o(lag_cnt)
  );

  function automatic int lagv(input int l);
    return int'(lag_cnt[l*CW +: CW]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(in_ready == m_busy, "R3 ready", int'(in_ready), int'(m_busy));
    chk(done == m_done, "R7 done", int'(done), int'(m_done));
    for (int l = 0; l < N; l++) begin
      int e;
      e = (l <= N - m_win) ? m_cnt[l] : 0;
      chk(lagv(l) == e, (l <= N - m_win) ? "R4 lag" : "R6 lag", lagv(l), e);
    end
  endtask

  task automatic model_edge(input bit st, input int wl, input bit v, input bit b);
    if (st) begin
      m_busy = 1; m_done = 0; m_n = 0;
      m_win = (wl >= 1 && wl <= N - 1) ? wl : N / 2;
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_fed.delete();
    end else if (m_busy && v) begin
      bit f;
      f = (m_n < m_win) ? b : 1'b0;
      if (b && f) m_cnt[0]++;
      for (int l = 1; l < N; l++)
        if (m_fed.size() >= l && b && m_fed[m_fed.size() - l]) m_cnt[l]++;
      m_fed.push_back(f);
      m_n++;
      if (m_n == N) begin m_busy = 0; m_done = 1; end
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit st, input int wl, input bit v, input bit b);
    start = st; win_len = wl[LW-1:0]; in_valid = v; in_bit = b;
    @(posedge clk);
    model_edge(st, wl, v, b);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_seq(input logic [N-1:0] bits, input int wl, input bit gaps);
    step(1, wl, 0, 0);
    for (int i = 0; i < N; i++) begin
      if (gaps && (i % 3 == 1)) step(0, wl, 0, 1);   // R3 stall
      step(0, wl, 1, bits[N-1-i]);
    end
    step(0, wl, 1, 1);   // R7 beat offered while done
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all();   // R1 reset state
    chk(lagv(0) == 0 && !in_ready && !done, "R1 reset", lagv(0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 worked example: 10101010, window 4 -> 2,0,2,0,2 then zeros
    run_seq(8'b10101010, 4, 0);
    chk(lagv(0) == 2, "R4 lag0", lagv(0), 2);
    chk(lagv(1) == 0, "R4 lag1", lagv(1), 0);
    chk(lagv(2) == 2, "R4 lag2", lagv(2), 2);
    chk(lagv(4) == 2, "R4 lag4", lagv(4), 2);
    chk(lagv(5) == 0, "R6 lag5", lagv(5), 0);
    chk(done && !in_ready, "R7 done held", int'(done), 1);

    // R5: ones only after the window -> every lag zero
    run_seq(8'b00001111, 4, 1);
    for (int l = 0; l < N; l++) chk(lagv(l) == 0, "R5 tail only", lagv(l), 0);

    // R8: illegal window 0 -> N/2; all ones gives 4 on lags 0..4
    run_seq(8'hFF, 0, 0);
    chk(lagv(0) == 4 && lagv(4) == 4, "R8 default window", lagv(4), 4);
    chk(lagv(5) == 0, "R8 R6 lag5", lagv(5), 0);

    // widest window 7: lags 0 and 1 only
    run_seq(8'hFF, 7, 1);
    chk(lagv(0) == 7 && lagv(1) == 7, "R4 window7", lagv(1), 7);
    chk(lagv(2) == 0, "R6 window7 lag2", lagv(2), 0);

    // R9: restart mid-run, counts cleared
    step(1, 2, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 2, 1, 1);
    step(1, 3, 0, 0);
    chk(lagv(0) == 0 && in_ready && !done, "R9 restart", lagv(0), 0);
    run_seq(8'b11011001, 3, 1);

    // R2: start after done clears counts
    step(1, 4, 0, 0);
    chk(lagv(0) == 0 && !done, "R2 clear", lagv(0), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule